// File: doc/BRIEF.md
# Two-Step Flash Code Assembler

This block is the digital back end of an 8-bit two-step subranging converter. It receives comparator results as thermometer vectors. The first is a six-comparator coarse estimate. The second and third come from one shared bank of eight flash comparators, which are used twice. From these vectors it builds the final 8-bit code. The analog ladders and comparators sit outside the block. The block tells them which group of eight coarse-ladder taps to present, and when to switch to the fine ladder.

A conversion runs in three steps. First, the estimate vector is decoded into a 2-bit range index. That index chooses a window of eight taps on a 32-tap coarse ladder, where each tap is 1/32 of full scale. Neighbouring windows overlap. If the first flash pass finds the input in the lower half of the chosen window, the range index is lowered by one before the five upper bits are formed. The second flash pass, taken against a fine ladder with 1/256 steps, gives the three lower bits. The finished code is registered and announced by a one-cycle strobe.

Thermometer vectors put the lowest comparator at bit 0. A vector is valid when its ones fill the low bits with no gap. An invalid vector is still resolved by its count of ones, and it also sets a sticky error flag.

Top module: `msf_code_assembler`

## Requirements
- R1: After reset, `code_o` is 0, `done_o` is 0, `fine_sel_o` is 0, `therm_err_o` is 0 and `win_base_o` is 0.
- R2: When `start_i` is sampled high while the block is idle, the ones in `est_therm_i` are counted as n. The count maps to a range index: 0 for n=0, 1 for n=1..2, 2 for n=3..4 and 3 for n=5..6. From the next cycle on, `win_base_o` shows the first tap of the window, max(0, min(24, 8*index-4)).
- R3: The conversion takes three clock edges. The edge that accepts start leads to the coarse flash cycle, where `fine_sel_o`=0 and `flash_therm_i` is sampled at the end of the cycle. The fine flash cycle follows, where `fine_sel_o`=1 and `flash_therm_i` is sampled again. `done_o` is then 1 for exactly one cycle, and the block is idle again.
- R4: `start_i` has no effect while a conversion is in progress. The window, the phase sequence and the result stay those of the running conversion.
- R5: The five upper code bits equal min(31, window base + ones in the first flash vector). A first-flash count below 4 lowers the range index by one whenever the index is above 0.
- R6: `code_o` = {upper five bits, min(7, ones in the second flash vector)}. It changes only on the edge that raises `done_o`, and it holds its value until the next conversion completes.
- R7: A sampled estimate or flash vector that is not a valid thermometer code is resolved by counting its ones and sets `therm_err_o`. Once set, `therm_err_o` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a conversion when the block is idle |
| est_therm_i | input | 6 | Estimator comparator outputs, bit 0 lowest |
| flash_therm_i | input | 8 | Shared flash comparator outputs, bit 0 lowest |
| win_base_o | output | 5 | First coarse-ladder tap of the selected window |
| fine_sel_o | output | 1 | High while the flash bank must see the fine ladder |
| code_o | output | 8 | Assembled conversion result |
| done_o | output | 1 | One-cycle strobe when `code_o` is updated |
| therm_err_o | output | 1 | Sticky flag for an invalid thermometer vector |

## Verification
The window base is due in the first cycle after the start edge. `fine_sel_o` rises one cycle later, and the code and `done_o` appear the cycle after that. Every check is sampled on a falling clock edge, after the register stage that produces it. The bench drives each flash vector in the falling-edge half of the phase that samples it. It checks that `done_o` has dropped and the code is held one cycle after the strobe. Held-high start and malformed vectors are mixed into a seeded random run, alongside directed cases for the window clamps, the downward correction and the fine-count clamp.

// File: rtl/msf_pkg.sv
package msf_pkg;
    localparam int EST_W    = 6;
    localparam int FLASH_W  = 8;
    localparam int IDX_W    = 2;
    localparam int MSB_W    = 5;
    localparam int LSB_W    = 3;
    localparam int CODE_W   = MSB_W + LSB_W;
    localparam int ECNT_W   = $clog2(EST_W + 1);
    localparam int FCNT_W   = $clog2(FLASH_W + 1);
    localparam int MAX_BASE = (1 << MSB_W) - FLASH_W;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_COARSE = 2'd1,
        PH_FINE   = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [MSB_W-1:0]   base;
        logic [MSB_W-1:0]   upper;
        logic [CODE_W-1:0]  code;
        logic               done;
        logic               err;
        logic [IDX_W-1:0]   idx;
    } regs_t;
endpackage

// File: rtl/msf_therm_count.sv
module msf_therm_count #(
    parameter int W     = 8,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec_i,
    output logic [CNT_W-1:0] ones_o,
    output logic             valid_o
);
    always_comb begin
        ones_o = '0;
        for (int i = 0; i < W; i++) begin
            ones_o = ones_o + CNT_W'(vec_i[i]);
        end
    end

    // a thermometer code has no 1 above a 0: adding one clears all set bits
    assign valid_o = ((vec_i & (vec_i + W'(1))) == '0);
endmodule

// File: rtl/msf_range_fix.sv
module msf_range_fix
    import msf_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [FCNT_W-1:0] ones_i,
    output logic [MSB_W-1:0]  upper_o
);
    localparam int HALF  = FLASH_W / 2;
    localparam int SUM_W = MSB_W + 1;

    logic               low_half;
    logic [IDX_W-1:0]   idx_fix;
    logic [SUM_W-1:0]   sum;

    always_comb begin
        low_half = (int'(ones_i) < HALF);
        idx_fix  = idx_i;
        sum      = SUM_W'(ones_i);
        if (idx_i != '0) begin
            if (low_half) begin
                idx_fix = idx_i - IDX_W'(1);
                sum = SUM_W'({idx_fix, 3'b000}) + SUM_W'(ones_i) + SUM_W'(HALF);
            end else begin
                sum = SUM_W'({idx_fix, 3'b000}) + SUM_W'(ones_i) - SUM_W'(HALF);
            end
        end
        upper_o = sum[SUM_W-1] ? '1 : sum[MSB_W-1:0];
    end
endmodule

// File: rtl/msf_code_assembler.sv
module msf_code_assembler
    import msf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [EST_W-1:0]   est_therm_i,
    input  logic [FLASH_W-1:0] flash_therm_i,
    output logic [MSB_W-1:0]   win_base_o,
    output logic               fine_sel_o,
    output logic [CODE_W-1:0]  code_o,
    output logic               done_o,
    output logic               therm_err_o
);
    logic [ECNT_W-1:0] est_ones;
    logic              est_ok;
    logic [FCNT_W-1:0] fl_ones;
    logic              fl_ok;
    logic [MSB_W-1:0]  upper_fix;
    regs_t             r_d, r_q;

    msf_therm_count #(.W(EST_W)) i_est_cnt (
        .vec_i(est_therm_i), .ones_o(est_ones), .valid_o(est_ok));

    msf_therm_count #(.W(FLASH_W)) i_fl_cnt (
        .vec_i(flash_therm_i), .ones_o(fl_ones), .valid_o(fl_ok));

    msf_range_fix i_fix (
        .idx_i(r_q.idx), .ones_i(fl_ones), .upper_o(upper_fix));

    function automatic logic [IDX_W-1:0] idx_of(input logic [ECNT_W-1:0] n);
        logic [ECNT_W:0] h;
        h = ({1'b0, n} + (ECNT_W+1)'(1)) >> 1;
        return (h > (ECNT_W+1)'(3)) ? IDX_W'(3) : h[IDX_W-1:0];
    endfunction

    function automatic logic [MSB_W-1:0] base_of(input logic [IDX_W-1:0] ix);
        int b;
        b = 8 * int'(ix) - FLASH_W / 2;
        if (b < 0) b = 0;
        if (b > MAX_BASE) b = MAX_BASE;
        return MSB_W'(b);
    endfunction

    always_comb begin
        logic [LSB_W-1:0] lsb;
        r_d      = r_q;
        r_d.done = 1'b0;
        lsb = (int'(fl_ones) > (1 << LSB_W) - 1) ? '1 : fl_ones[LSB_W-1:0];
        unique case (r_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    r_d.idx   = idx_of(est_ones);
                    r_d.base  = base_of(idx_of(est_ones));
                    r_d.phase = PH_COARSE;
                    if (!est_ok) r_d.err = 1'b1;
                end
            end
            PH_COARSE: begin
                r_d.upper = upper_fix;
                r_d.phase = PH_FINE;
                if (!fl_ok) r_d.err = 1'b1;
            end
            PH_FINE: begin
                r_d.code  = {r_q.upper, lsb};
                r_d.done  = 1'b1;
                r_d.phase = PH_IDLE;
                if (!fl_ok) r_d.err = 1'b1;
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign win_base_o  = r_q.base;
    assign fine_sel_o  = (r_q.phase == PH_FINE);
    assign code_o      = r_q.code;
    assign done_o      = r_q.done;
    assign therm_err_o = r_q.err;

    // R3: the strobe lasts one cycle and only follows the fine phase
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r3_done_after_fine: assert property (@(posedge clk) disable iff (!rst_n)
        fine_sel_o |=> done_o && !fine_sel_o);
    a_r3_fine_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        fine_sel_o |-> !done_o);
    // R7: error flag is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        therm_err_o |=> therm_err_o);
    // R6: code only moves together with the strobe
    a_r6_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fine_sel_o) |-> $stable(code_o));
    // R2: window base stays on a 4-tap boundary inside the ladder
    a_r2_base_range: assert property (@(posedge clk) disable iff (!rst_n)
        win_base_o[1:0] == 2'b00 && int'(win_base_o) <= MAX_BASE);
    // R4: window stays fixed through the fine phase
    a_r4_base_stable: assert property (@(posedge clk) disable iff (!rst_n)
        fine_sel_o |-> $stable(win_base_o));
endmodule

// File: tb/test_msf_code_assembler.sv
module test_msf_code_assembler;
    localparam time PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [5:0] est_therm_i = '0;
    logic [7:0] flash_therm_i = '0;
    logic [4:0] win_base_o;
    logic       fine_sel_o;
    logic [7:0] code_o;
    logic       done_o;
    logic       therm_err_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic err_exp = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    msf_code_assembler i_msf_code_assembler (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .est_therm_i(est_therm_i), .flash_therm_i(flash_therm_i),
        .win_base_o(win_base_o), .fine_sel_o(fine_sel_o),
        .code_o(code_o), .done_o(done_o), .therm_err_o(therm_err_o));

    function automatic int ones(input logic [7:0] v);
        int c = 0;
        for (int i = 0; i < 8; i++) c += v[i];
        return c;
    endfunction

    function automatic bit is_therm(input logic [7:0] v, input int w);
        bit seen0 = 0;
        for (int i = 0; i < w; i++) begin
            if (!v[i]) seen0 = 1;
            else if (seen0) return 0;
        end
        return 1;
    endfunction

    function automatic int exp_base(input int n);
        int ix;
        if (n == 0) ix = 0;
        else if (n <= 2) ix = 1;
        else if (n <= 4) ix = 2;
        else ix = 3;
        return (ix == 0) ? 0 : ((8*ix - 4 > 24) ? 24 : 8*ix - 4);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] therm(input int n);
        return 8'((1 << n) - 1);
    endfunction

    // one conversion; hold_start keeps start_i high while busy (R4)
    task automatic convert(input logic [5:0] e, input logic [7:0] f1,
                           input logic [7:0] f2, input bit hold_start);
        int base, up, lo;
        logic [7:0] prev_code;
        base = exp_base(ones({2'b00, e}));
        up = base + ones(f1);
        if (up > 31) up = 31;
        lo = (ones(f2) > 7) ? 7 : ones(f2);
        prev_code = code_o;
        @(negedge clk);
        start_i = 1'b1;
        est_therm_i = e;
        if (!is_therm({2'b00, e}, 6)) err_exp = 1'b1;
        @(negedge clk);
        start_i = hold_start;
        est_therm_i = ~e;
        check("R2 window base", win_base_o, base);
        check("R3 coarse phase fine_sel", fine_sel_o, 0);
        check("R6 code held before done", code_o, prev_code);
        flash_therm_i = f1;
        if (!is_therm(f1, 8)) err_exp = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R3 fine phase fine_sel", fine_sel_o, 1);
        check("R4 window kept", win_base_o, base);
        flash_therm_i = f2;
        if (!is_therm(f2, 8)) err_exp = 1'b1;
        @(negedge clk);
        check("R3 done strobe", done_o, 1);
        check("R5/R6 code", code_o, up * 8 + lo);
        check("R7 error flag", therm_err_o, err_exp);
        @(negedge clk);
        check("R3 done one cycle", done_o, 0);
        check("R6 code hold", code_o, up * 8 + lo);
        check("R4 idle after done", fine_sel_o, 0);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        #(PERIOD * 3);
        @(negedge clk);
        // R1 reset state
        check("R1 code", code_o, 0);
        check("R1 done", done_o, 0);
        check("R1 fine_sel", fine_sel_o, 0);
        check("R1 err", therm_err_o, 0);
        check("R1 base", win_base_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 each estimator count, mid-window flash
        for (int n = 0; n <= 6; n++) convert(6'((1 << n) - 1), therm(4), therm(3), 0);
        // R5 downward correction and lowest/highest flash counts
        convert(6'b000111, therm(0), therm(0), 0);
        convert(6'b000111, therm(3), therm(8), 0);
        convert(6'b111111, therm(8), therm(7), 0);
        convert(6'b000000, therm(8), therm(1), 0);
        // R4 start held high during conversion
        convert(6'b000011, therm(5), therm(2), 1);
        // R7 invalid vectors, then flag must stay set
        convert(6'b000101, therm(4), therm(2), 0);
        convert(6'b000001, 8'b1011_0111, 8'b0000_0110, 0);
        // random run; flag stays sticky
        for (int k = 0; k < 300; k++) begin
            logic [5:0] e;
            logic [7:0] a, b;
            e = 6'((1 << $urandom_range(0, 6)) - 1);
            a = therm($urandom_range(0, 8));
            b = therm($urandom_range(0, 8));
            if ($urandom_range(0, 9) == 0) a = 8'($urandom);
            if ($urandom_range(0, 9) == 0) e = 6'($urandom);
            convert(e, a, b, bit'($urandom_range(0, 1)));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule